// File: doc/BRIEF.md
# External Oscillator Loss Monitor

This block supervises the external high-speed oscillator and reacts in hardware when its clock stops. A free-running reference clock from an internal oscillator drives all decision logic. The monitored clock flips a toggle flop in its own domain; that toggle crosses into the reference domain through a synchroniser, and each change restarts a timeout counter. If the counter reaches a programmable number of reference cycles with no change seen, the oscillator is declared lost.

Software switches monitoring on with an enable bit, but the detector only arms once the oscillator reports that its startup delay is over. It disarms whenever the oscillator is turned off. A detected loss triggers several outputs in the same cycle. The oscillator is turned off, a break event goes to the advanced timers, and a sticky flag drives a non-maskable interrupt. If the lost clock was feeding the system clock, a fallback is requested, and if it was the reference of a PLL in use, the PLL is shut down too. After a loss the monitor stays silent until it is re-armed.

Top module: `osc_loss_guard`

## Requirements
- R1: No loss is reported unless `monitor_en`, `osc_en` and `osc_ready` are all high. Dropping any of them disarms the detector within one reference cycle.
- R2: Suppose the detector arms at reference edge E0 and no monitored-clock change is seen after that. Then `brk_pulse` and `nmi` go high after edge E0+T+1, where T is `timeout` (T >= 1), and both are low after edge E0+T.
- R3: While the monitored clock keeps changing more often than every `timeout` reference cycles, no loss is reported. If it stops, a loss follows.
- R4: `brk_pulse` is high for exactly one reference cycle per loss. No further pulse occurs until the monitor is re-armed, either by deasserting `monitor_en` or `osc_en` and then asserting it again.
- R5: `nmi` stays high after a loss until `fail_clr` is high for a cycle, and it is low after that edge. A `fail_clr` with no pending flag has no effect. A `fail_clr` in the same cycle as a new loss leaves `nmi` high.
- R6: `osc_off` pulses high in the same cycle as every `brk_pulse`.
- R7: `fallback_req` pulses with the loss in two cases: when `sysclk_sel` is 2 (external oscillator direct), or when it is 3 (PLL) with `pll_src_ext` high. It stays low for `sysclk_sel` 0 or 1 (internal oscillators) and for 3 with `pll_src_ext` low.
- R8: `pll_off` pulses with the loss only when `sysclk_sel` is 3 and `pll_src_ext` is high.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock from the internal oscillator |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored external oscillator clock (may stop) |
| monitor_en | input | 1 | Software enable of the monitor |
| osc_en | input | 1 | Current enable state of the external oscillator |
| osc_ready | input | 1 | Oscillator startup delay has elapsed |
| timeout | input | TMO_W | Loss timeout in reference cycles |
| sysclk_sel | input | 2 | Active system clock: 0,1 internal, 2 external, 3 PLL |
| pll_src_ext | input | 1 | PLL reference is the external oscillator (divided or not) |
| fail_clr | input | 1 | Write-one-to-clear strobe of the loss flag |
| brk_pulse | output | 1 | One-cycle break event to the advanced timers |
| osc_off | output | 1 | One-cycle request to clear the oscillator enable |
| pll_off | output | 1 | One-cycle request to clear the PLL enable |
| fallback_req | output | 1 | One-cycle request to move the system clock to a safe source |
| nmi | output | 1 | Sticky loss flag driving the non-maskable interrupt |

## Verification
Suppose the timeout counter kept the wrong value, or the armed state were stale. The cycle of `brk_pulse` would then move away from edge E0+T+1, and the exact-cycle check catches that. A stuck single-shot latch would show as a second break pulse, or none at all, within a few timeout periods of holding the enable high. A wrong decode of the active clock path shows up on `fallback_req` or `pll_off` in the very cycle of the loss. Flag bugs appear on `nmi` one edge after a clear strobe.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;

    typedef enum logic [1:0] {
        SRC_LPI = 2'd0,
        SRC_HSI = 2'd1,
        SRC_EXT = 2'd2,
        SRC_PLL = 2'd3
    } sysclk_src_e;

    typedef struct packed {
        logic brk;
        logic osc_off;
        logic pll_off;
        logic fallback;
    } fail_act_t;

    localparam fail_act_t ACT_NONE = '{brk: 1'b0, osc_off: 1'b0, pll_off: 1'b0, fallback: 1'b0};

    function automatic logic pll_on_ext(sysclk_src_e sel, logic pll_ext);
        return (sel == SRC_PLL) && pll_ext;
    endfunction

    function automatic logic ext_in_use(sysclk_src_e sel, logic pll_ext);
        return (sel == SRC_EXT) || pll_on_ext(sel, pll_ext);
    endfunction

    function automatic fail_act_t build_action(sysclk_src_e sel, logic pll_ext);
        fail_act_t a;
        a.brk      = 1'b1;
        a.osc_off  = 1'b1;
        a.pll_off  = pll_on_ext(sel, pll_ext);
        a.fallback = ext_in_use(sel, pll_ext);
        return a;
    endfunction

endpackage

// File: rtl/osc_guard_toggle.sv
module osc_guard_toggle (
    input  logic mon_clk,
    input  logic rst,
    output logic tog
);
    // Runs on the monitored clock; every edge flips the level.
    always_ff @(posedge mon_clk) begin
        if (rst) tog <= 1'b0;
        else     tog <= ~tog;
    end
endmodule

// File: rtl/osc_guard_sync.sv
module osc_guard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic chg
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh;
    logic          prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[LAST-1:0], din};
            end
        end
    endgenerate

    // Edge detection after the synchroniser only.
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sh[LAST];
    end

    assign chg = sh[LAST] ^ prev;
endmodule

// File: rtl/osc_guard_timer.sv
module osc_guard_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             chg,
    input  logic [TMO_W-1:0] timeout,
    output logic             hit
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !armed || chg) cnt <= '0;
        else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    // A change seen in the same cycle wins over the timeout.
    assign hit = armed && !chg && (cnt >= timeout);
endmodule

// File: rtl/osc_guard_ctrl.sv
module osc_guard_ctrl
    import osc_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        monitor_en,
    input  logic        osc_en,
    input  logic        osc_ready,
    input  logic        hit,
    input  sysclk_src_e sel,
    input  logic        pll_ext,
    input  logic        fail_clr,
    output logic        armed,
    output fail_act_t   act,
    output logic        flag
);
    logic tripped;
    logic allow;

    assign allow = monitor_en && osc_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            tripped <= 1'b0;
        end else begin
            armed <= allow && osc_ready && !tripped && !hit;
            if (!allow)   tripped <= 1'b0;
            else if (hit) tripped <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      act <= ACT_NONE;
        else if (hit) act <= build_action(sel, pll_ext);
        else          act <= ACT_NONE;
    end

    // A new loss takes priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (fail_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/osc_loss_guard.sv
module osc_loss_guard
    import osc_guard_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             mon_clk,
    input  logic             monitor_en,
    input  logic             osc_en,
    input  logic             osc_ready,
    input  logic [TMO_W-1:0] timeout,
    input  logic [1:0]       sysclk_sel,
    input  logic             pll_src_ext,
    input  logic             fail_clr,
    output logic             brk_pulse,
    output logic             osc_off,
    output logic             pll_off,
    output logic             fallback_req,
    output logic             nmi
);
    logic      tog;
    logic      chg;
    logic      armed;
    logic      hit;
    fail_act_t act;

    osc_guard_toggle u_tog (
        .mon_clk (mon_clk),
        .rst     (rst),
        .tog     (tog)
    );

    osc_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (ref_clk),
        .rst (rst),
        .din (tog),
        .chg (chg)
    );

    osc_guard_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (ref_clk),
        .rst     (rst),
        .armed   (armed),
        .chg     (chg),
        .timeout (timeout),
        .hit     (hit)
    );

    osc_guard_ctrl u_ctrl (
        .clk        (ref_clk),
        .rst        (rst),
        .monitor_en (monitor_en),
        .osc_en     (osc_en),
        .osc_ready  (osc_ready),
        .hit        (hit),
        .sel        (sysclk_src_e'(sysclk_sel)),
        .pll_ext    (pll_src_ext),
        .fail_clr   (fail_clr),
        .armed      (armed),
        .act        (act),
        .flag       (nmi)
    );

    assign brk_pulse    = act.brk;
    assign osc_off      = act.osc_off;
    assign pll_off      = act.pll_off;
    assign fallback_req = act.fallback;
endmodule

// File: rtl/osc_loss_guard_chk.sv
module osc_loss_guard_chk (
    input logic clk,
    input logic rst,
    input logic monitor_en,
    input logic fail_clr,
    input logic hit,
    input logic brk,
    input logic osc_off,
    input logic pll_off,
    input logic fallback_req,
    input logic nmi
);
    a_r4_break_single: assert property (@(posedge clk) disable iff (rst)
        brk |=> !brk);

    a_r5_flag_on_fail: assert property (@(posedge clk) disable iff (rst)
        brk |-> nmi);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (nmi && !fail_clr) |=> nmi);

    a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
        (nmi && fail_clr && !hit) |=> !nmi);

    a_r6_osc_off_with_break: assert property (@(posedge clk) disable iff (rst)
        brk |-> osc_off);

    a_r7_fallback_with_break: assert property (@(posedge clk) disable iff (rst)
        fallback_req |-> brk);

    a_r8_pll_off_needs_fallback: assert property (@(posedge clk) disable iff (rst)
        pll_off |-> fallback_req);

    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !monitor_en |-> ##2 !brk);
endmodule

bind osc_loss_guard osc_loss_guard_chk u_chk (
    .clk          (ref_clk),
    .rst          (rst),
    .monitor_en   (monitor_en),
    .fail_clr     (fail_clr),
    .hit          (hit),
    .brk          (brk_pulse),
    .osc_off      (osc_off),
    .pll_off      (pll_off),
    .fallback_req (fallback_req),
    .nmi          (nmi)
);

// File: tb/osc_loss_guard_bench.sv
module osc_loss_guard_bench;
    localparam int TMO_W = 16;

    logic             ref_clk = 1'b0;
    logic             mon_clk = 1'b0;
    logic             mon_run = 1'b1;
    logic             rst = 1'b1;
    logic             monitor_en = 1'b0;
    logic             osc_en = 1'b0;
    logic             osc_ready = 1'b0;
    logic [TMO_W-1:0] timeout = 16'd4;
    logic [1:0]       sysclk_sel = 2'd0;
    logic             pll_src_ext = 1'b0;
    logic             fail_clr = 1'b0;
    logic             brk_pulse, osc_off, pll_off, fallback_req, nmi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    osc_loss_guard #(.TMO_W(TMO_W)) u_osc_loss_guard (
        .ref_clk      (ref_clk),
        .rst          (rst),
        .mon_clk      (mon_clk),
        .monitor_en   (monitor_en),
        .osc_en       (osc_en),
        .osc_ready    (osc_ready),
        .timeout      (timeout),
        .sysclk_sel   (sysclk_sel),
        .pll_src_ext  (pll_src_ext),
        .fail_clr     (fail_clr),
        .brk_pulse    (brk_pulse),
        .osc_off      (osc_off),
        .pll_off      (pll_off),
        .fallback_req (fallback_req),
        .nmi          (nmi)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #15;
        if (mon_run) mon_clk = ~mon_clk;
    end

    // {sysclk_sel[1:0], pll_src_ext, expected fallback, expected pll_off}
    localparam logic [4:0] VEC [0:7] = '{
        5'b00_0_0_0, 5'b00_1_0_0, 5'b01_0_0_0, 5'b01_1_0_0,
        5'b10_0_1_0, 5'b10_1_1_0, 5'b11_0_0_0, 5'b11_1_1_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    // Drop and raise the enable so the detector arms at the next edge (E0),
    // then stop at the negedge after E0+T: the loss is due at the next edge.
    task automatic rearm_to_edge();
        monitor_en = 1'b0;
        cycles(1);
        monitor_en = 1'b1;
        cycles(int'(timeout) + 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int brk_cnt;
        cycles(10);
        rst = 1'b0;
        cycles(1);
        // R9: reset state
        chk("R9 brk", brk_pulse, 0);
        chk("R9 osc_off", osc_off, 0);
        chk("R9 pll_off", pll_off, 0);
        chk("R9 fallback", fallback_req, 0);
        chk("R9 nmi", nmi, 0);

        // Stop the oscillator and let the synchroniser drain.
        mon_run = 1'b0;
        cycles(10);

        // R1: not ready, then not enabled -> silent
        monitor_en = 1'b1; osc_en = 1'b1; osc_ready = 1'b0;
        cycles(20);
        chk("R1 not ready nmi", nmi, 0);
        osc_ready = 1'b1; monitor_en = 1'b0;
        cycles(20);
        chk("R1 disabled nmi", nmi, 0);

        // R5: clear with nothing pending has no effect
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        chk("R5 idle clear nmi", nmi, 0);

        // Table walk: R2 timing, R6/R7/R8 decode, R5 clear
        for (int i = 0; i < 8; i++) begin
            sysclk_sel  = VEC[i][4:3];
            pll_src_ext = VEC[i][2];
            rearm_to_edge();
            chk("R2 early brk", brk_pulse, 0);
            chk("R2 early nmi", nmi, 0);
            cycles(1);
            chk("R2 brk at E0+T+1", brk_pulse, 1);
            chk("R6 osc_off", osc_off, 1);
            chk("R7 fallback", fallback_req, {31'd0, VEC[i][1]});
            chk("R8 pll_off", pll_off, {31'd0, VEC[i][0]});
            cycles(1);
            chk("R4 brk one cycle", brk_pulse, 0);
            chk("R5 nmi held", nmi, 1);
            fail_clr = 1'b1;
            cycles(1);
            fail_clr = 1'b0;
            chk("R5 cleared", nmi, 0);
        end

        // R4: single shot while enable stays high, then re-arm
        sysclk_sel = 2'd2; pll_src_ext = 1'b0;
        rearm_to_edge();
        brk_cnt = 0;
        for (int c = 0; c < 40; c++) begin
            cycles(1);
            if (brk_pulse) brk_cnt++;
        end
        chk("R4 one pulse per loss", brk_cnt, 1);
        chk("R5 sticky nmi", nmi, 1);

        // R5: clear in same cycle as a new loss keeps the flag
        rearm_to_edge();
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        chk("R4 re-armed brk", brk_pulse, 1);
        chk("R5 clear vs loss", nmi, 1);
        cycles(3);
        chk("R5 still set", nmi, 1);
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        chk("R5 final clear", nmi, 0);

        // R3: running clock never trips, stopped clock does
        timeout = 16'd12;
        mon_run = 1'b1;
        monitor_en = 1'b0;
        cycles(1);
        monitor_en = 1'b1;
        brk_cnt = 0;
        for (int c = 0; c < 200; c++) begin
            cycles(1);
            if (brk_pulse) brk_cnt++;
        end
        chk("R3 running no loss", brk_cnt, 0);
        chk("R3 running nmi", nmi, 0);
        mon_run = 1'b0;
        cycles(40);
        chk("R3 stopped loss", nmi, 1);

        // R1: osc_en low disarms immediately
        fail_clr = 1'b1;
        cycles(1);
        fail_clr = 1'b0;
        osc_en = 1'b0;
        monitor_en = 1'b0;
        cycles(1);
        monitor_en = 1'b1;
        cycles(40);
        chk("R1 osc off nmi", nmi, 0);

        finish_run();
    end
endmodule